// File: doc/BRIEF.md
# Single-Byte Two-Wire Slave

This block is a slave on a two-wire serial control bus that carries exactly one data byte per transaction. It samples the bus clock and data lines with the system clock and finds START and STOP conditions. It takes in the address byte and compares it with a seven-bit address. The upper five bits of that address are fixed, and the two lowest come from strap pins. On a match the block acknowledges. It then either accepts one byte from the host or returns one byte to it.

On the parallel side, a received byte appears with a one-cycle strobe. The byte returned on a read is taken from an input register supplied by the surrounding logic. The data line is driven only as an open-drain pull-down enable. The block never holds the clock low, and after its single data byte it stays off the bus until the next START.

Top module: `i2c_byte_slave`

## Requirements
- R1: While reset is asserted, `sda_oe` and `rx_valid` are 0.
- R2: The address byte is sent MSB first as 0,0,1,1,1,`strap_hi`,`strap_lo`,R/W. On a match the slave raises `sda_oe` at the SCL fall after the eighth address bit and keeps it high until the next SCL fall, so the line is low during the ninth clock.
- R3: A non-matching address is not acknowledged. Every later bit up to the next START is ignored: there is no acknowledge and no strobe.
- R4: When R/W is 0, the next eight bits are taken MSB first. The strobe `rx_valid` is high for one cycle with `rx_byte` holding the byte, and the slave acknowledges that byte during the ninth clock.
- R5: When R/W is 1, `tx_byte` is sampled at the SCL fall that ends the address acknowledge. Its bits are driven MSB first, active-low through `sda_oe`, and change only at SCL falls. The line is released after the eighth bit, and an ACK or NACK from the host has no effect.
- R6: After the single data byte and its acknowledge, further bytes are neither acknowledged nor strobed nor driven until the next START.
- R7: A STOP (SDA rising while SCL is high) returns the slave to idle with `sda_oe` 0.
- R8: A START (SDA falling while SCL is high) received in the middle of any byte abandons that byte and restarts address reception.
- R9: A line change registers on the third system clock edge after it: two synchronizer flops, then edge detection. SDA changes while SCL is low are never taken as START or STOP.
- R10: Behaviour does not depend on the bus rate for any SCL or SDA phase of at least four system clocks. A slow and a fast phase length both operate correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap_hi | input | 1 | Strap for address bit 1 |
| strap_lo | input | 1 | Strap for address bit 0 |
| tx_byte | input | 8 | Byte returned to the host on a read |
| sda_oe | output | 1 | Pull-down enable for the open-drain data line |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Last byte written by the host |

## Verification
The START detector and the byte-shifting logic can act in the same system cycle. This happens when the host issues a repeated START partway through an address byte or a data byte: the condition must win over the half-filled shift register and bit count. The bench provokes this by cutting a write byte after three bits and an address byte after two bits. It then sends a fresh address. A behavioural model is compared against the acknowledge level, `sda_oe` and the strobe on every clock. The case is judged by whether the new address is acknowledged and whether the byte written after it arrives intact.

// File: rtl/i2c_byte_slave.sv
module i2c_byte_slave #(
  parameter logic [4:0] ADDR_PREFIX = 5'b00111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       strap_hi,
  input  logic       strap_lo,
  input  logic [7:0] tx_byte,
  output logic       sda_oe,
  output logic       rx_valid,
  output logic [7:0] rx_byte
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK_SET, S_AACK_HOLD,
    S_WDATA, S_DACK_SET, S_DACK_HOLD, S_RDATA
  } st_t;

  st_t              st;
  logic [1:0]       scl_sy, sda_sy;
  logic             scl_q, sda_q;
  logic [BYTE_W-2:0] sh;
  logic [CNT_W-1:0] cnt;
  logic             rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  logic [BYTE_W-1:0] full;
  logic [6:0]        my_addr;
  logic              last_bit;
  assign full     = {sh, sda_s};
  assign my_addr  = {ADDR_PREFIX, strap_hi, strap_lo};
  assign last_bit = (cnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '0;
      cnt      <= '0;
      rw       <= 1'b0;
      sda_oe   <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (start_det) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR: if (scl_rise) begin
            sh  <= full[BYTE_W-2:0];
            cnt <= cnt + 1'b1;
            if (last_bit) begin
              rw <= sda_s;
              st <= (full[BYTE_W-1:1] == my_addr) ? S_AACK_SET : S_IDLE;
            end
          end
          S_AACK_SET: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= S_AACK_HOLD;
          end
          S_AACK_HOLD: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              sh     <= tx_byte[BYTE_W-2:0];
              sda_oe <= ~tx_byte[BYTE_W-1];
              st     <= S_RDATA;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WDATA;
            end
          end
          S_WDATA: if (scl_rise) begin
            sh  <= full[BYTE_W-2:0];
            cnt <= cnt + 1'b1;
            if (last_bit) begin
              rx_byte  <= full;
              rx_valid <= 1'b1;
              st       <= S_DACK_SET;
            end
          end
          S_DACK_SET: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= S_DACK_HOLD;
          end
          S_DACK_HOLD: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_IDLE;
          end
          S_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == '0) begin
                sda_oe <= 1'b0;
                st     <= S_IDLE;
              end else begin
                sh     <= {sh[BYTE_W-3:0], 1'b0};
                sda_oe <= ~sh[BYTE_W-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_byte_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic rx_valid,
  input logic scl_q,
  input logic start_det,
  input logic stop_det
);
  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!sda_oe && !rx_valid);
    end
  end

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4
  strobe_line_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !sda_oe);

  // R5
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q);

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && !rx_valid));
endmodule

bind i2c_byte_slave i2c_byte_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .rx_valid (rx_valid),
  .scl_q    (scl_q),
  .start_det(start_det),
  .stop_det (stop_det)
);

// File: tb/test_i2c_byte_slave.sv
module test_i2c_byte_slave;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       scl_h = 1'b1;
  logic       sda_h = 1'b1;
  logic       strap_hi = 1'b1;
  logic       strap_lo = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       sda_oe, rx_valid;
  logic [7:0] rx_byte;
  logic       sda_line;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  i2c_byte_slave i_i2c_byte_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line),
    .strap_hi(strap_hi), .strap_lo(strap_lo), .tx_byte(tx_byte),
    .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  int    n_cmp = 0, n_bad = 0;
  string req = "R1";
  int    ph = 6;
  bit    finished = 0;

  // behavioural reference: mode 0 idle,1 addr,2/3 addr ack,4 write,5/6 data ack,7 read
  int m_mode = 0, m_bits = 0, m_acc = 0, m_byte = 0;
  bit m_rw = 0, m_oe = 0, m_pulse = 0, m_scl = 1, m_sda = 1;
  logic [7:0] m_tx = 0;

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_apply(input bit s, input bit d);
    bit ns;
    ns = d & ~m_oe;
    m_pulse = 0;
    if (m_scl && s && m_sda && !ns) begin
      m_mode = 1; m_bits = 0; m_acc = 0; m_oe = 0;
    end else if (m_scl && s && !m_sda && ns) begin
      m_mode = 0; m_oe = 0;
    end else if (!m_scl && s) begin
      if (m_mode == 1 || m_mode == 4) begin
        m_acc = ((m_acc << 1) | ns) & 255;
        m_bits++;
        if (m_bits == 8) begin
          if (m_mode == 1) begin
            m_rw = ns;
            m_mode = ((m_acc >> 1) == (28 + 2*strap_hi + strap_lo)) ? 2 : 0;
          end else begin
            m_byte = m_acc; m_pulse = 1; m_mode = 5;
          end
        end
      end else if (m_mode == 7) m_bits++;
    end else if (m_scl && !s) begin
      case (m_mode)
        2: begin m_oe = 1; m_mode = 3; end
        3: begin
          m_bits = 0; m_acc = 0;
          if (m_rw) begin m_tx = tx_byte; m_oe = !tx_byte[7]; m_mode = 7; end
          else begin m_oe = 0; m_mode = 4; end
        end
        5: begin m_oe = 1; m_mode = 6; end
        6: begin m_oe = 0; m_mode = 0; end
        7: if (m_bits == 8) begin m_oe = 0; m_mode = 0; end
           else m_oe = !m_tx[7 - m_bits];
        default: ;
      endcase
    end
    m_scl = s;
    m_sda = d & ~m_oe;
  endtask

  task automatic step(input bit s, input bit d);
    bit old_oe;
    old_oe = m_oe;
    scl_h = s; sda_h = d;
    model_apply(s, d);
    for (int k = 1; k <= ph; k++) begin
      @(negedge clk);
      if (k < SETTLE) begin
        cmp("sda_oe", sda_oe, old_oe);
        cmp("rx_valid", rx_valid, 0);
      end else begin
        cmp("sda_oe", sda_oe, m_oe);
        cmp("rx_valid", rx_valid, (k == SETTLE) ? m_pulse : 1'b0);
        if (k == SETTLE && m_pulse) cmp("rx_byte", rx_byte, m_byte);
      end
    end
  endtask

  task automatic do_start(); step(1, 0); step(0, 0); endtask
  task automatic do_rstart(); step(0, 1); step(1, 1); step(1, 0); step(0, 0); endtask
  task automatic do_stop(); step(0, 0); step(1, 0); step(1, 1); endtask
  task automatic send_bit(input bit b); step(0, b); step(1, b); step(0, b); endtask

  task automatic write_byte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    step(0, 1); step(1, 1);
    ack = !sda_line;
    step(0, 1);
  endtask

  task automatic read_byte(input bit host_nack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      step(0, 1); step(1, 1);
      v[i] = sda_line;
      step(0, 1);
    end
    step(0, host_nack); step(1, host_nack); step(0, host_nack);
  endtask

  function automatic logic [7:0] addr_b(input bit rw);
    return {5'b00111, strap_hi, strap_lo, rw};
  endfunction

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    req = "R1";
    cmp("reset sda_oe", sda_oe, 0);
    cmp("reset rx_valid", rx_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 R7: matching write
    req = "R2"; do_start(); write_byte(addr_b(0), ack); cmp("addr ack", ack, 1);
    req = "R4"; write_byte(8'hA5, ack); cmp("data ack", ack, 1);
    cmp("rx_byte", rx_byte, 8'hA5);
    req = "R7"; do_stop(); cmp("idle oe", sda_oe, 0);

    // R5: read with NACK, then read with ACK and a surplus byte (R6)
    req = "R5"; tx_byte = 8'h96;
    do_start(); write_byte(addr_b(1), ack); cmp("read addr ack", ack, 1);
    read_byte(1, v); cmp("read data", v, 8'h96); do_stop();
    tx_byte = 8'h3C;
    do_start(); write_byte(addr_b(1), ack); cmp("read addr ack", ack, 1);
    read_byte(0, v); cmp("read data host ack", v, 8'h3C);
    req = "R6"; read_byte(1, v); cmp("surplus read released", v, 8'hFF); do_stop();

    // R6: second write byte refused
    req = "R6"; do_start(); write_byte(addr_b(0), ack);
    write_byte(8'h11, ack); cmp("first byte ack", ack, 1);
    write_byte(8'h22, ack); cmp("second byte nack", ack, 0);
    cmp("rx_byte kept", rx_byte, 8'h11); do_stop();

    // R3: foreign address and wrong strap
    req = "R3"; do_start(); write_byte(8'hA0, ack); cmp("foreign nack", ack, 0);
    write_byte(8'h00, ack); cmp("ignored data", ack, 0);
    cmp("rx_byte untouched", rx_byte, 8'h11); do_stop();
    do_start(); write_byte(addr_b(0) ^ 8'h02, ack); cmp("strap mismatch nack", ack, 0); do_stop();

    // R2: other strap setting
    req = "R2"; strap_hi = 1'b0; strap_lo = 1'b1;
    do_start(); write_byte(addr_b(0), ack); cmp("new strap ack", ack, 1);
    write_byte(8'hC3, ack); cmp("rx_byte", rx_byte, 8'hC3); do_stop();

    // R8: repeated START mid data byte and mid address byte
    req = "R8"; do_start(); write_byte(addr_b(0), ack);
    send_bit(1); send_bit(0); send_bit(1);
    do_rstart(); send_bit(0); send_bit(0);
    do_rstart(); write_byte(addr_b(0), ack); cmp("restart addr ack", ack, 1);
    write_byte(8'h5A, ack); cmp("restart data ack", ack, 1);
    cmp("restart rx_byte", rx_byte, 8'h5A); do_stop();

    // R9: SDA toggles while SCL low are not conditions
    req = "R9"; step(0, 1); step(0, 0); step(0, 1);
    write_byte(addr_b(0), ack); cmp("no start no ack", ack, 0);
    step(1, 1);
    do_start(); write_byte(addr_b(0), ack); cmp("real start ack", ack, 1); do_stop();

    // R10: fast and slow phases
    req = "R10"; ph = 4;
    do_start(); write_byte(addr_b(0), ack); cmp("fast addr ack", ack, 1);
    write_byte(8'h69, ack); cmp("fast rx_byte", rx_byte, 8'h69); do_stop();
    ph = 16; tx_byte = 8'hE1;
    do_start(); write_byte(addr_b(1), ack); cmp("slow addr ack", ack, 1);
    read_byte(1, v); cmp("slow read", v, 8'hE1); do_stop();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule